// File: doc/BRIEF.md
# Program Counter and Return Stack with Instruction Skip

This unit holds the program counter of a small microcontroller core, together with a hardware return stack and the global interrupt enable. Each cycle the decoder hands it one-bit strobes for the instruction now executing: plain advance, skip-condition-true, jump, call, return, return-from-interrupt and interrupt entry. A 14-bit operand and two page bits supply the target of a jump or call. The caller evaluates every skip condition (compare, increment/decrement or bit test) and presents only the result.

Redirecting instructions cost two cycles. The PC loads the new address at once, and in the following cycle `flush_o` marks the stale fetch as a bubble while the PC holds. A true skip also costs one extra cycle. The PC steps past the executing instruction, the following instruction runs as a squashed bubble with `flush_o` high, and the PC steps again. Strobes that arrive during a bubble belong to a discarded instruction and are ignored.

The return stack keeps the eight most recent return addresses. A push onto a full stack drops the oldest entry and sets a sticky overflow flag. Interrupt entry saves the address of the interrupted instruction, turns global interrupts off and jumps to a fixed vector. Return-from-interrupt turns them back on.

Top module: `pcs_flow_top`

## Requirements
- R1: After reset `pc_o` is 0x0000, `flush_o`, `gie_o` and `ovf_o` are 0, and the return stack is empty.
- R2: Outside a bubble, with only `adv_i` high, `pc_o` rises by one on the next cycle and wraps from 0xFFFF to 0. With no strobe high, `pc_o` holds.
- R3: A jump loads `pc_o` with {`page_i`, `tgt_i`}: the page bits become PC bits 15..14 and the operand becomes bits 13..0. `flush_o` is high for exactly the next cycle, and the PC holds during that cycle.
- R4: A call pushes the address of the following instruction (PC + 1) and then loads the PC and a bubble exactly as a jump does.
- R5: A return loads `pc_o` from the most recent stack entry, removes that entry, and is followed by one bubble cycle.
- R6: A return-from-interrupt behaves as a return and also sets `gie_o` to 1.
- R7: A skip strobe advances the PC by one and raises `flush_o` for the next cycle. During that bubble the PC advances by one again, for a total of +2 over two cycles.
- R8: While `flush_o` is high, every strobe input is ignored: the stack, `gie_o` and the PC change only as the bubble itself dictates.
- R9: Interrupt entry pushes the current PC, clears `gie_o`, loads `pc_o` with the vector 0x0008 and is followed by one bubble cycle.
- R10: The stack holds 8 entries. A push while 8 are held discards the oldest entry and sets `ovf_o`, which stays 1 until reset. Returns then yield the newest 8 addresses, newest first.
- R11: When several strobes are high together, exactly one acts, in this order of precedence: interrupt entry, return-from-interrupt, return, call, jump, skip, advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Executing instruction completes normally |
| skip_i | input | 1 | Skip condition of the executing instruction is true |
| jmp_i | input | 1 | Executing instruction is a jump |
| call_i | input | 1 | Executing instruction is a call |
| ret_i | input | 1 | Executing instruction is a return |
| reti_i | input | 1 | Executing instruction is a return-from-interrupt |
| irq_i | input | 1 | Enter the interrupt vector in place of the executing instruction |
| tgt_i | input | 14 | Jump/call operand, PC bits 13..0 |
| page_i | input | 2 | Page bits, PC bits 15..14 of a jump/call target |
| pc_o | output | 16 | Program counter |
| flush_o | output | 1 | Current fetch is a bubble and must be discarded |
| gie_o | output | 1 | Global interrupt enable |
| ovf_o | output | 1 | Sticky return stack overflow flag |

## Verification
The assertions assume that a return or return-from-interrupt never arrives while the stack is empty, since the popped value is then undefined. The bench tracks its own stack depth and only issues a return when an entry is present. They also assume that interrupt requests are gated by the caller, so the unit enters the vector whenever `irq_i` is accepted, whatever the state of `gie_o`. The stimulus raises several strobes at once only in the precedence tests, and it drives strobes into bubble cycles on purpose to show that they are discarded.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // Action chosen for the executing instruction
    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADV,
        OP_SKIP,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_RETI,
        OP_IRQ
    } flow_op_e;

    // Bubble kind following the current cycle
    typedef enum logic [1:0] {
        BUB_RUN,
        BUB_SKIP,
        BUB_LOAD
    } bubble_e;

endpackage

// File: rtl/pcs_op_sel.sv
module pcs_op_sel
    import pcs_pkg::*;
(
    input  logic     run_i,
    input  logic     irq_i,
    input  logic     reti_i,
    input  logic     ret_i,
    input  logic     call_i,
    input  logic     jmp_i,
    input  logic     skip_i,
    input  logic     adv_i,
    output flow_op_e op_o
);

    // Fixed precedence; nothing acts inside a bubble
    always_comb begin
        op_o = OP_NONE;
        if (run_i) begin
            if (irq_i)       op_o = OP_IRQ;
            else if (reti_i) op_o = OP_RETI;
            else if (ret_i)  op_o = OP_RET;
            else if (call_i) op_o = OP_CALL;
            else if (jmp_i)  op_o = OP_JMP;
            else if (skip_i) op_o = OP_SKIP;
            else if (adv_i)  op_o = OP_ADV;
        end
    end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] top_o,
    output logic         ovf_o
);

    // DEPTH must be a power of two so the write index wraps naturally
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } stk_t;

    stk_t stk_q, stk_d;
    logic [PW-1:0] rd_idx;

    assign rd_idx = stk_q.wp - 1'b1;
    assign top_o  = stk_q.mem[rd_idx];
    assign ovf_o  = stk_q.ovf;

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            stk_d.mem[stk_q.wp] = push_val_i;
            stk_d.wp            = stk_q.wp + 1'b1;
            if (stk_q.cnt == CW'(DEPTH)) begin
                stk_d.ovf = 1'b1;          // oldest slot is the one overwritten
            end else begin
                stk_d.cnt = stk_q.cnt + 1'b1;
            end
        end else if (pop_i) begin
            stk_d.wp = rd_idx;
            if (stk_q.cnt != '0) stk_d.cnt = stk_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R11
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (stk_q.cnt != '0)); // R5
    AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && stk_q.cnt == CW'(DEPTH)) |=> ovf_o); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R10

endmodule

// File: rtl/pcs_flow_top.sv
module pcs_flow_top
    import pcs_pkg::*;
#(
    parameter int              PC_W    = 16,
    parameter int              TGT_W   = 14,
    parameter int              DEPTH   = 8,
    parameter logic [PC_W-1:0] IRQ_VEC = 16'h0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              skip_i,
    input  logic              jmp_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              reti_i,
    input  logic              irq_i,
    input  logic [TGT_W-1:0]  tgt_i,
    input  logic [PC_W-TGT_W-1:0] page_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              flush_o,
    output logic              gie_o,
    output logic              ovf_o
);

    localparam int PAGE_W = PC_W - TGT_W;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        bubble_e         bub;
        logic            gie;
    } flow_t;

    flow_t           cur_q, nxt_d;
    flow_op_e        op;
    logic            push, pop;
    logic [PC_W-1:0] push_val, stk_top, target;

    assign target = {page_i, tgt_i};

    pcs_op_sel u_op_sel (
        .run_i  (cur_q.bub == BUB_RUN),
        .irq_i  (irq_i),
        .reti_i (reti_i),
        .ret_i  (ret_i),
        .call_i (call_i),
        .jmp_i  (jmp_i),
        .skip_i (skip_i),
        .adv_i  (adv_i),
        .op_o   (op)
    );

    pcs_ret_stack #(
        .W     (PC_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (push_val),
        .top_o      (stk_top),
        .ovf_o      (ovf_o)
    );

    always_comb begin
        nxt_d    = cur_q;
        push     = 1'b0;
        pop      = 1'b0;
        push_val = '0;
        nxt_d.bub = BUB_RUN;
        case (cur_q.bub)
            BUB_SKIP: nxt_d.pc = cur_q.pc + 1'b1;   // step over squashed slot
            BUB_LOAD: ;                              // refetch at loaded PC
            default: begin
                case (op)
                    OP_IRQ: begin
                        push      = 1'b1;
                        push_val  = cur_q.pc;
                        nxt_d.pc  = IRQ_VEC;
                        nxt_d.gie = 1'b0;
                        nxt_d.bub = BUB_LOAD;
                    end
                    OP_RETI: begin
                        pop       = 1'b1;
                        nxt_d.pc  = stk_top;
                        nxt_d.gie = 1'b1;
                        nxt_d.bub = BUB_LOAD;
                    end
                    OP_RET: begin
                        pop       = 1'b1;
                        nxt_d.pc  = stk_top;
                        nxt_d.bub = BUB_LOAD;
                    end
                    OP_CALL: begin
                        push      = 1'b1;
                        push_val  = cur_q.pc + 1'b1;
                        nxt_d.pc  = target;
                        nxt_d.bub = BUB_LOAD;
                    end
                    OP_JMP: begin
                        nxt_d.pc  = target;
                        nxt_d.bub = BUB_LOAD;
                    end
                    OP_SKIP: begin
                        nxt_d.pc  = cur_q.pc + 1'b1;
                        nxt_d.bub = BUB_SKIP;
                    end
                    OP_ADV:  nxt_d.pc = cur_q.pc + 1'b1;
                    default: ;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pc  <= '0;
            cur_q.bub <= BUB_RUN;
            cur_q.gie <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pc_o    = cur_q.pc;
    assign flush_o = (cur_q.bub != BUB_RUN);
    assign gie_o   = cur_q.gie;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && !flush_o) |=> $stable(pc_o)); // R2
    AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o); // R3
    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_JMP) |=> (flush_o && pc_o == $past(target))); // R3
    AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SKIP) |=> (flush_o && pc_o == $past(pc_o) + 1'b1)); // R7
    AST_BUBBLE_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> $stable(gie_o)); // R8
    AST_RETI_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RETI) |=> gie_o); // R6
    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IRQ) |=> (!gie_o && pc_o == IRQ_VEC)); // R9

endmodule

// File: tb/test_pcs_flow_top.sv
module test_pcs_flow_top;

    localparam logic [6:0] S_IRQ  = 7'b1000000;
    localparam logic [6:0] S_RETI = 7'b0100000;
    localparam logic [6:0] S_RET  = 7'b0010000;
    localparam logic [6:0] S_CALL = 7'b0001000;
    localparam logic [6:0] S_JMP  = 7'b0000100;
    localparam logic [6:0] S_SKIP = 7'b0000010;
    localparam logic [6:0] S_ADV  = 7'b0000001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  strb = '0;
    logic [13:0] tgt = '0;
    logic [1:0]  page = '0;
    logic [15:0] pc;
    logic        flush, gie, ovf;

    int vectors = 0;
    int errors  = 0;

    // reference model state
    int         m_pc = 0;
    int         m_bub = 0;     // 0 run, 1 after skip, 2 after load
    bit         m_gie = 0;
    bit         m_ovf = 0;
    int         m_stk[$];

    always #10 clk = ~clk;     // 50 MHz

    pcs_flow_top i_pcs_flow_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (strb[0]),
        .skip_i  (strb[1]),
        .jmp_i   (strb[2]),
        .call_i  (strb[3]),
        .ret_i   (strb[4]),
        .reti_i  (strb[5]),
        .irq_i   (strb[6]),
        .tgt_i   (tgt),
        .page_i  (page),
        .pc_o    (pc),
        .flush_o (flush),
        .gie_o   (gie),
        .ovf_o   (ovf)
    );

    task automatic m_push(input int v);
        if (m_stk.size() == 8) begin
            void'(m_stk.pop_front());
            m_ovf = 1'b1;
        end
        m_stk.push_back(v);
    endtask

    task automatic compare(input string tag);
        logic [18:0] act, exp;
        act = {pc, flush, gie, ovf};
        exp = {m_pc[15:0], (m_bub != 0), m_gie, m_ovf};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pc/flush/gie/ovf actual %h/%b/%b/%b expected %h/%b/%b/%b",
                     tag, pc, flush, gie, ovf, m_pc[15:0], (m_bub != 0), m_gie, m_ovf);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(input string tag, input logic [6:0] s,
                       input logic [1:0] pg = 2'd0, input logic [13:0] tg = 14'd0);
        int npc, nbub;
        bit ngie;
        strb = s; page = pg; tgt = tg;
        npc = m_pc; nbub = 0; ngie = m_gie;
        if (m_bub == 1)      npc = (m_pc + 1) & 16'hFFFF;
        else if (m_bub == 2) npc = m_pc;
        else if (s[6]) begin m_push(m_pc); npc = 16'h0008; ngie = 0; nbub = 2; end
        else if (s[5]) begin npc = m_stk.pop_back(); ngie = 1; nbub = 2; end
        else if (s[4]) begin npc = m_stk.pop_back(); nbub = 2; end
        else if (s[3]) begin m_push((m_pc + 1) & 16'hFFFF); npc = {pg, tg}; nbub = 2; end
        else if (s[2]) begin npc = {pg, tg}; nbub = 2; end
        else if (s[1]) begin npc = (m_pc + 1) & 16'hFFFF; nbub = 1; end
        else if (s[0]) npc = (m_pc + 1) & 16'hFFFF;
        @(posedge clk);
        @(negedge clk);
        m_pc = npc; m_bub = nbub; m_gie = ngie;
        compare(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        cyc("R1 idle after reset", 7'd0);

        // R2 advance and hold
        for (int k = 0; k < 3; k++) cyc("R2 advance", S_ADV);
        cyc("R2 hold", 7'd0);

        // R3 jump, R8 strobes in bubble ignored
        cyc("R3 jump", S_JMP, 2'd2, 14'h1234);
        cyc("R8 call in bubble ignored", S_CALL, 2'd1, 14'h0001);
        cyc("R3 after bubble", S_ADV);

        // R4 call, R5 return
        cyc("R4 call", S_CALL, 2'd0, 14'h0100);
        cyc("R4 bubble", 7'd0);
        cyc("R4 advance in callee", S_ADV);
        cyc("R5 return", S_RET);
        cyc("R5 bubble", S_RET);

        // R7 skip, R8 jump in skip bubble ignored
        cyc("R7 skip", S_SKIP);
        cyc("R8 jump in skip bubble ignored", S_JMP, 2'd3, 14'h3FFF);
        cyc("R7 advance after skip", S_ADV);

        // R9 interrupt entry, R6 return-from-interrupt
        cyc("R9 interrupt entry", S_IRQ);
        cyc("R9 bubble", S_IRQ);
        cyc("R9 handler", S_ADV);
        cyc("R6 reti", S_RETI);
        cyc("R6 bubble", 7'd0);

        // R11 precedence
        cyc("R11 all strobes irq wins", 7'h7F, 2'd1, 14'h0055);
        cyc("R11 bubble", 7'd0);
        cyc("R11 reti over ret/call", S_RETI | S_RET | S_CALL, 2'd1, 14'h0055);
        cyc("R11 bubble", 7'd0);
        cyc("R11 call over jmp", S_CALL | S_JMP, 2'd1, 14'h0066);
        cyc("R11 bubble", 7'd0);
        cyc("R11 jmp over skip/adv", S_JMP | S_SKIP | S_ADV, 2'd2, 14'h0777);
        cyc("R11 bubble", 7'd0);
        cyc("R11 ret over call", S_RET | S_CALL, 2'd3, 14'h0001);
        cyc("R11 bubble", 7'd0);
        cyc("R11 skip over adv", S_SKIP | S_ADV);
        cyc("R11 skip bubble", 7'd0);

        // R10 overflow: nine nested calls, then eight returns
        for (int k = 0; k < 9; k++) begin
            cyc("R10 call", S_CALL, 2'(k), 14'(16 * k + 3));
            cyc("R10 bubble", 7'd0);
            cyc("R10 advance", S_ADV);
        end
        for (int k = 0; k < 8; k++) begin
            cyc("R10 return", S_RET);
            cyc("R10 bubble", 7'd0);
        end
        cyc("R10 overflow sticky", S_ADV);

        // R2 wrap
        cyc("R2 jump to top", S_JMP, 2'd3, 14'h3FFF);
        cyc("R2 bubble", 7'd0);
        cyc("R2 wrap to zero", S_ADV);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule